// File: doc/BRIEF.md
# Vector Slide-By-One Permutation Unit

This block performs the single-element slide operations of a vector unit. A source register image is shifted by one element position, up or down. A scalar operand fills the position that the shift leaves empty. The caller supplies the instruction word, the element width, the active length, the scalar, the source image, the mask image and the present contents of the destination. One cycle later the block returns the new destination image. Elements that are masked off or lie beyond the active length keep their old values.

The instruction word is decoded inside the block. The integer-scalar and floating-point-scalar forms are accepted. Every other encoding, and every operand combination that is not allowed, is reported as illegal; in that case the destination comes back unchanged. The floating-point form has its own legality rules but uses the integer datapath unchanged, so the scalar bits are inserted exactly as given.

Top module: `vslide1_unit`

## Requirements
- R1: Up slide (funct6 001110): for each writable element i, element 0 receives the scalar and element i > 0 receives source element i-1.
- R2: Down slide (funct6 001111): for each writable element i, element vl-1 receives the scalar and element i < vl-1 receives source element i+1.
- R3: When instruction bit 25 is 0 (masking on) and mask image bit i is 0, destination element i keeps its old value. When bit 25 is 1, the mask image has no effect.
- R4: Destination elements with index >= vl are never written, and vl = 0 leaves the whole destination unchanged.
- R5: With vl = 1, both directions write only the scalar into element 0, unless that element is masked off.
- R6: The scalar is cut to its low SEW bits, where `sew_i` 0/1/2/3 selects 8/16/32/64 bits. The floating-point form (funct3 101) gives results identical bit for bit to the integer form (funct3 110).
- R7: An operation is legal only with major opcode bits [6:0] = 1010111, funct6 bits [31:26] of 001110 or 001111, and funct3 bits [14:12] of 110 or 101. Anything else is flagged illegal.
- R8: The floating-point form is illegal when `fp_en_i` is 0 or when SEW is 8.
- R9: The up form is illegal when the destination field [11:7] equals the source field [24:20]. Any form is illegal when vl exceeds VLEN/SEW.
- R10: `done_o` is high exactly in the cycle after a cycle in which `start_i` is high. On an illegal operation `illegal_o` is set and `vd_o` equals the old destination. Between operations, `vd_o` and `illegal_o` hold their values.
- R11: After reset, `done_o`, `illegal_o` and `vd_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one operation in this cycle |
| instr_i | input | 32 | Instruction word to decode |
| fp_en_i | input | 1 | Single-precision floating-point support enabled |
| sew_i | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| vl_i | input | $clog2(VLEN/8+1) | Active length in elements |
| scalar_i | input | 64 | Scalar to insert (low SEW bits used) |
| vs2_i | input | VLEN | Source register image |
| mask_i | input | VLEN | Mask image; bit i governs element i |
| vd_old_i | input | VLEN | Present destination contents |
| done_o | output | 1 | Result valid (one-cycle pulse) |
| illegal_o | output | 1 | Last operation was rejected |
| vd_o | output | VLEN | New destination image |

## Verification
Random operations spread over all four element widths, both directions, masked and unmasked forms, and active lengths from zero up to and past the element count. These separate off-by-one mistakes in the neighbour index from mistakes in the position where the scalar goes. Directed cases cover the edges: vl of 0 and 1, an alternating mask, a scalar with its high bits set, and the same operands run in integer and floating-point form. Together they show whether truncation, masking and the bound on vl each work on their own. Each illegal encoding and operand rule is tried once, so that a missing legality term cannot be hidden by another term.

// File: rtl/vslide1_pkg.sv
package vslide1_pkg;
  typedef enum logic [1:0] {SEW8 = 2'd0, SEW16 = 2'd1, SEW32 = 2'd2, SEW64 = 2'd3} sew_e;

  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [5:0] F6_UP   = 6'b001110;
  localparam logic [5:0] F6_DN   = 6'b001111;
  localparam logic [2:0] F3_INT  = 3'b110;
  localparam logic [2:0] F3_FP   = 3'b101;

  typedef struct packed {
    logic legal;
    logic up;
    logic vm;
    logic fp;
  } slide_op_t;
endpackage

// File: rtl/vslide1_decode.sv
module vslide1_decode
  import vslide1_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int VL_W = 5
) (
  input  logic [5:0]      f6_i,
  input  logic            vm_i,
  input  logic [4:0]      vs2_idx_i,
  input  logic [2:0]      f3_i,
  input  logic [4:0]      vd_idx_i,
  input  logic [6:0]      opc_i,
  input  logic            fp_en_i,
  input  sew_e            sew_i,
  input  logic [VL_W-1:0] vl_i,
  output slide_op_t       op_o
);
  logic [VL_W-1:0] vlmax;
  logic is_up, is_dn, is_int, is_fp, fp_bad, overlap, too_long;

  always_comb begin
    vlmax    = VL_W'((VLEN / 8) >> sew_i);
    is_up    = (f6_i == F6_UP);
    is_dn    = (f6_i == F6_DN);
    is_int   = (f3_i == F3_INT);
    is_fp    = (f3_i == F3_FP);
    fp_bad   = is_fp && (!fp_en_i || sew_i == SEW8);
    overlap  = is_up && (vd_idx_i == vs2_idx_i);
    too_long = vl_i > vlmax;
    op_o.legal = (opc_i == OPC_VEC) && (is_up || is_dn) && (is_int || is_fp)
                 && !fp_bad && !overlap && !too_long;
    op_o.up    = is_up;
    op_o.vm    = vm_i;
    op_o.fp    = is_fp;
  end
endmodule

// File: rtl/vslide1_lanes.sv
module vslide1_lanes #(
  parameter int VLEN = 128,
  parameter int EW   = 8,
  parameter int VL_W = 5,
  localparam int NE  = VLEN / EW
) (
  input  logic            up_i,
  input  logic            vm_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [EW-1:0]   scalar_i,
  input  logic [VLEN-1:0] vs2_i,
  input  logic [NE-1:0]   mask_i,
  input  logic [VLEN-1:0] vd_old_i,
  output logic [VLEN-1:0] res_o
);
  for (genvar e = 0; e < NE; e++) begin : g_elem
    logic [EW-1:0] below, above, nv;
    logic          wr_en, is_last;

    if (e == 0) begin : g_lo
      assign below = scalar_i;
    end else begin : g_lo_n
      assign below = vs2_i[(e-1)*EW +: EW];
    end

    if (e == NE - 1) begin : g_hi
      assign above = scalar_i;
    end else begin : g_hi_n
      assign above = vs2_i[(e+1)*EW +: EW];
    end

    assign is_last = (vl_i == VL_W'(e + 1));
    assign wr_en   = (VL_W'(e) < vl_i) && (vm_i || mask_i[e]);
    assign nv      = up_i ? below : (is_last ? scalar_i : above);
    assign res_o[e*EW +: EW] = wr_en ? nv : vd_old_i[e*EW +: EW];
  end
endmodule

// File: rtl/vslide1_unit.sv
module vslide1_unit
  import vslide1_pkg::*;
#(
  parameter int VLEN  = 128,
  localparam int VL_W = $clog2(VLEN / 8 + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic            fp_en_i,
  input  logic [1:0]      sew_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [63:0]     scalar_i,
  input  logic [VLEN-1:0] vs2_i,
  input  logic [VLEN-1:0] mask_i,
  input  logic [VLEN-1:0] vd_old_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic [VLEN-1:0] vd_o
);
  slide_op_t       op;
  sew_e            sew;
  logic [VLEN-1:0] res_w [4];
  logic [VLEN-1:0] res_sel;
  logic            unused_rs1;

  assign sew        = sew_e'(sew_i);
  assign unused_rs1 = ^instr_i[19:15];

  vslide1_decode #(.VLEN(VLEN), .VL_W(VL_W)) u_dec (
    .f6_i      (instr_i[31:26]),
    .vm_i      (instr_i[25]),
    .vs2_idx_i (instr_i[24:20]),
    .f3_i      (instr_i[14:12]),
    .vd_idx_i  (instr_i[11:7]),
    .opc_i     (instr_i[6:0]),
    .fp_en_i   (fp_en_i),
    .sew_i     (sew),
    .vl_i      (vl_i),
    .op_o      (op)
  );

  // one datapath per element width; fp form shares them
  for (genvar w = 0; w < 4; w++) begin : g_width
    localparam int EW = 8 << w;
    localparam int NE = VLEN / EW;
    vslide1_lanes #(.VLEN(VLEN), .EW(EW), .VL_W(VL_W)) u_lanes (
      .up_i     (op.up),
      .vm_i     (op.vm),
      .vl_i     (vl_i),
      .scalar_i (scalar_i[EW-1:0]),
      .vs2_i    (vs2_i),
      .mask_i   (mask_i[NE-1:0]),
      .vd_old_i (vd_old_i),
      .res_o    (res_w[w])
    );
  end

  assign res_sel = res_w[sew_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      vd_o      <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        illegal_o <= !op.legal;
        vd_o      <= op.legal ? res_sel : vd_old_i;
      end
    end
  end
endmodule

// File: rtl/vslide1_chk.sv
module vslide1_chk #(
  parameter int VLEN  = 128,
  localparam int VL_W = $clog2(VLEN / 8 + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [31:0]     instr_i,
  input logic            fp_en_i,
  input logic [1:0]      sew_i,
  input logic [VL_W-1:0] vl_i,
  input logic [63:0]     scalar_i,
  input logic [VLEN-1:0] mask_i,
  input logic [VLEN-1:0] vd_old_i,
  input logic            done_o,
  input logic            illegal_o,
  input logic [VLEN-1:0] vd_o
);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_no_spurious_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(vd_o) && $stable(illegal_o));
  assert_illegal_keeps_old_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !illegal_o || vd_o == $past(vd_old_i));
  assert_zero_vl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && vl_i == '0 |=> vd_o == $past(vd_old_i));
  assert_all_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !instr_i[25] && mask_i == '0 |=> vd_o == $past(vd_old_i));
  assert_fp_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && instr_i[14:12] == 3'b101 && !fp_en_i |=> illegal_o);
  assert_up_scalar_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !instr_i[26] && instr_i[25] && vl_i != '0
    |=> illegal_o || vd_o[7:0] == $past(scalar_i[7:0]));

  for (genvar b = 0; b < VLEN / 8; b++) begin : g_tail
    assert_tail_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && sew_i == 2'd0 && VL_W'(b) >= vl_i
      |=> vd_o[b*8 +: 8] == $past(vd_old_i[b*8 +: 8]));
  end
endmodule

bind vslide1_unit vslide1_chk #(.VLEN(VLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .instr_i   (instr_i),
  .fp_en_i   (fp_en_i),
  .sew_i     (sew_i),
  .vl_i      (vl_i),
  .scalar_i  (scalar_i),
  .mask_i    (mask_i),
  .vd_old_i  (vd_old_i),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .vd_o      (vd_o)
);

// File: tb/tb_vslide1_unit.sv
`timescale 1ns/1ps
module tb_vslide1_unit;
  localparam int VLEN = 128;
  localparam int VL_W = $clog2(VLEN / 8 + 1);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic            fp_en_i = 1'b1;
  logic [1:0]      sew_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic [63:0]     scalar_i = '0;
  logic [VLEN-1:0] vs2_i = '0, mask_i = '0, vd_old_i = '0;
  logic            done_o, illegal_o;
  logic [VLEN-1:0] vd_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  vslide1_unit #(.VLEN(VLEN)) dut (.*);

  function automatic logic [31:0] mk(input bit up, input bit fp, input bit vm,
                                     input logic [4:0] vd, input logic [4:0] vs2);
    return {up ? 6'b001110 : 6'b001111, vm, vs2, 5'd3, fp ? 3'b101 : 3'b110, vd, 7'b1010111};
  endfunction

  function automatic bit exp_ill(input logic [31:0] ins, input logic fpen,
                                 input logic [1:0] sew, input logic [VL_W-1:0] vl);
    bit up = ins[31:26] == 6'b001110;
    bit dn = ins[31:26] == 6'b001111;
    bit fp = ins[14:12] == 3'b101;
    bit in = ins[14:12] == 3'b110;
    int ew = 8 << sew;
    bit bad = ins[6:0] != 7'b1010111 || !(up || dn) || !(fp || in);
    bad = bad || (fp && (!fpen || sew == 2'd0));
    bad = bad || (up && ins[11:7] == ins[24:20]);
    bad = bad || int'(vl) > VLEN / ew;
    return bad;
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [31:0] ins, input logic fpen,
      input logic [1:0] sew, input logic [VL_W-1:0] vl, input logic [63:0] sc,
      input logic [VLEN-1:0] vs2, input logic [VLEN-1:0] msk, input logic [VLEN-1:0] old);
    logic [VLEN-1:0] r = old;
    int ew = 8 << sew;
    int ne = VLEN / ew;
    int n = int'(vl);
    bit up = ins[31:26] == 6'b001110;
    if (exp_ill(ins, fpen, sew, vl)) return old;
    for (int i = 0; i < ne; i++) begin
      if (i < n && (ins[25] || msk[i])) begin
        for (int k = 0; k < ew; k++) begin
          if (up) r[i*ew+k] = (i == 0) ? sc[k] : vs2[(i-1)*ew+k];
          else    r[i*ew+k] = (i == n - 1) ? sc[k] : vs2[(i+1)*ew+k];
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] ins, input logic fpen,
      input logic [1:0] sew, input logic [VL_W-1:0] vl, input logic [63:0] sc,
      input logic [VLEN-1:0] vs2, input logic [VLEN-1:0] msk, input logic [VLEN-1:0] old);
    logic [VLEN-1:0] e = model(ins, fpen, sew, vl, sc, vs2, msk, old);
    bit ei = exp_ill(ins, fpen, sew, vl);
    @(negedge clk_i);
    instr_i = ins; fp_en_i = fpen; sew_i = sew; vl_i = vl; scalar_i = sc;
    vs2_i = vs2; mask_i = msk; vd_old_i = old; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    vd_old_i = ~old;
    chk(done_o == 1'b1, "R10", VLEN'(done_o), VLEN'(1));
    chk(illegal_o == ei, req, VLEN'(illegal_o), VLEN'(ei));
    chk(vd_o == e, req, vd_o, e);
    @(negedge clk_i);
    chk(done_o == 1'b0 && vd_o == e, "R10", vd_o, e);
  endtask

  function automatic logic [VLEN-1:0] rnd_img();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] a, b, o, r_int;
    void'($urandom(32'd2024));
    a = rnd_img(); b = rnd_img(); o = rnd_img();
    #12;
    chk(done_o == 1'b0 && illegal_o == 1'b0 && vd_o == '0, "R11", vd_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // main function, full length
    run_op("R1", mk(1, 0, 1, 5'd1, 5'd2), 1, 2'd1, VL_W'(8),  64'h1234_5678_9abc_def0, a, b, o);
    run_op("R2", mk(0, 0, 1, 5'd1, 5'd2), 1, 2'd1, VL_W'(8),  64'h1234_5678_9abc_def0, a, b, o);
    run_op("R2", mk(0, 0, 1, 5'd1, 5'd2), 1, 2'd3, VL_W'(2),  64'hfeed_beef_0bad_cafe, a, b, o);
    // masking
    run_op("R3", mk(1, 0, 0, 5'd4, 5'd5), 1, 2'd0, VL_W'(16), 64'h55, a, {VLEN/2{2'b01}}, o);
    run_op("R3", mk(0, 0, 0, 5'd4, 5'd5), 1, 2'd2, VL_W'(4),  64'h77, a, {VLEN/2{2'b10}}, o);
    run_op("R3", mk(0, 0, 1, 5'd4, 5'd5), 1, 2'd0, VL_W'(16), 64'h66, a, '0, o);
    // active length bound
    run_op("R4", mk(1, 0, 1, 5'd4, 5'd5), 1, 2'd0, VL_W'(0),  64'h11, a, b, o);
    run_op("R4", mk(0, 0, 1, 5'd4, 5'd5), 1, 2'd0, VL_W'(5),  64'h22, a, b, o);
    // vl = 1
    run_op("R5", mk(1, 0, 1, 5'd4, 5'd5), 1, 2'd2, VL_W'(1),  64'hdead_beef, a, b, o);
    chk(vd_o[31:0] == 32'hdead_beef && vd_o[VLEN-1:32] == o[VLEN-1:32], "R5", vd_o, {o[VLEN-1:32], 32'hdead_beef});
    run_op("R5", mk(0, 0, 1, 5'd4, 5'd5), 1, 2'd2, VL_W'(1),  64'hcafe_f00d, a, b, o);
    chk(vd_o[31:0] == 32'hcafe_f00d && vd_o[VLEN-1:32] == o[VLEN-1:32], "R5", vd_o, {o[VLEN-1:32], 32'hcafe_f00d});
    run_op("R5", mk(0, 0, 0, 5'd4, 5'd5), 1, 2'd2, VL_W'(1),  64'hcafe_f00d, a, '0, o);
    // truncation and fp equivalence
    run_op("R6", mk(1, 0, 1, 5'd4, 5'd5), 1, 2'd0, VL_W'(3),  64'hffff_ffff_ffff_ffab, a, b, o);
    chk(vd_o[7:0] == 8'hab && vd_o[VLEN-1:24] == o[VLEN-1:24], "R6", vd_o, {o[VLEN-1:24], a[15:0], 8'hab});
    run_op("R6", mk(0, 0, 1, 5'd4, 5'd5), 1, 2'd1, VL_W'(6),  64'h0123_4567_89ab_3c00, a, b, o);
    r_int = vd_o;
    run_op("R6", mk(0, 1, 1, 5'd4, 5'd5), 1, 2'd1, VL_W'(6),  64'h0123_4567_89ab_3c00, a, b, o);
    chk(vd_o == r_int, "R6", vd_o, r_int);
    // encoding legality
    run_op("R7", mk(1, 0, 1, 5'd4, 5'd5) ^ 32'h1, 1, 2'd0, VL_W'(4), 64'h9, a, b, o);
    run_op("R7", {6'b001101, mk(1, 0, 1, 5'd4, 5'd5) & 32'h03ff_ffff}, 1, 2'd0, VL_W'(4), 64'h9, a, b, o);
    run_op("R7", mk(0, 0, 1, 5'd4, 5'd5) & 32'hffff_8fff, 1, 2'd0, VL_W'(4), 64'h9, a, b, o);
    // fp rules
    run_op("R8", mk(0, 1, 1, 5'd4, 5'd5), 1, 2'd0, VL_W'(4), 64'h9, a, b, o);
    run_op("R8", mk(1, 1, 1, 5'd4, 5'd5), 0, 2'd2, VL_W'(4), 64'h9, a, b, o);
    // operand rules
    run_op("R9", mk(1, 0, 1, 5'd7, 5'd7), 1, 2'd1, VL_W'(4), 64'h9, a, b, o);
    run_op("R9", mk(0, 0, 1, 5'd7, 5'd7), 1, 2'd1, VL_W'(4), 64'h9, a, b, o);
    run_op("R9", mk(0, 0, 1, 5'd6, 5'd7), 1, 2'd3, VL_W'(3), 64'h9, a, b, o);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      bit up = $urandom % 2;
      bit fp = $urandom % 2;
      bit vm = $urandom % 2;
      logic [1:0] sew = 2'($urandom % 4);
      int vmax = VLEN / (8 << sew);
      int vl = ($urandom % 16 == 0) ? vmax + 1 : int'($urandom % (vmax + 1));
      logic [4:0] vd = 5'($urandom);
      logic [4:0] vs = ($urandom % 20 == 0) ? vd : vd + 5'd1;
      bit fpen = ($urandom % 10) != 0;
      if (vl > VLEN / 8) vl = VLEN / 8;
      run_op(vm ? (up ? "R1" : "R2") : "R3", mk(up, fp, vm, vd, vs), fpen, sew, VL_W'(vl),
             {$urandom, $urandom}, rnd_img(), rnd_img(), rnd_img());
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule